// File: doc/BRIEF.md
# Persistent Register Bank Controller

This block holds the persistent settings of a four-channel digitally set resistor: for each channel four 6-bit data registers and one volatile wiper position. It takes commands that an upstream serial decoder has already framed and decoded, one `cmd_valid` pulse per command, together with the serial chip-select level. It answers reads one cycle after the command. It moves values between the wipers and the data registers and updates the wipers at once. Writes into persistent storage are held back until chip select is released.

A store is any write into a data register: a direct data write, a single-channel wiper-to-register copy, or a copy of all four wipers at once. Such a command is only noted as pending during the frame. It takes effect on the clock in which `cs_n` is seen rising. The store then starts a busy window of `BUSY_CYCLES` clocks, which models the cell programming time. During that window `wip` is high and further stores are refused. A low level on `wp_n` refuses stores outright. Volatile moves into the wipers are never blocked. After reset release, every wiper is loaded from its channel's register 0. The data registers come out of reset with a parameterised pattern that stands in for the stored contents.

Top module: `nvb_ctrl`

## Requirements
- R1: During reset `wip` and `rd_valid` are 0. Data register r of channel c resets to (DR_SEED + 4*c + r) mod 64. In the first clock after reset release each wiper is loaded from its channel's register 0 and appears on `wiper_o[6c+5:6c]`. Commands in that clock are ignored.
- R2: A data write (op 4) changes the addressed register only at the clock in which `cs_n` is sampled rising after the command. A read of that register before the rise still returns the old value.
- R3: Read ops (1 = wiper of `cmd_pot`, 3 = register `cmd_reg` of `cmd_pot`, 9 = status) raise `rd_valid` for one cycle in the clock after the command. `rd_data` carries the value. For status, `rd_data` is {5'b0, wip}.
- R4: Each committed store drives `wip` high from the clock after the commit for exactly BUSY_CYCLES clocks.
- R5: A single wiper-to-register transfer (op 6) writes the wiper of `cmd_pot` into its register `cmd_reg`. It uses the wiper value held at the commit.
- R6: A global wiper-to-register transfer (op 8) writes each channel's wiper into that channel's register `cmd_reg` in a single store with one busy window.
- R7: Register-to-wiper transfers, single (op 5, channel `cmd_pot`) and global (op 7, every channel), load the wipers from register `cmd_reg` in the clock after the command. They need no chip-select rise and start no busy window.
- R8: A store command issued while `wp_n` is 0 is discarded. The registers keep their values and no busy window follows.
- R9: A store command issued while `wip` is 1 is discarded. A status read during the window still returns 1.
- R10: A chip-select rise with no pending store changes no register and starts no busy window.
- R11: A wiper write (op 2) sets the wiper of `cmd_pot` to `cmd_data` in the clock after the command. It is volatile and is allowed while `wp_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select level; its rise commits a pending store |
| wp_n | input | 1 | Write protect, low refuses stores |
| cmd_valid | input | 1 | One-cycle strobe of a decoded command |
| cmd_op | input | 4 | Operation code (see requirements) |
| cmd_pot | input | 2 | Channel select |
| cmd_reg | input | 2 | Data register index |
| cmd_data | input | 6 | Write value |
| rd_valid | output | 1 | Read answer strobe |
| rd_data | output | 6 | Read answer |
| wip | output | 1 | Store in progress |
| wiper_o | output | 24 | Four wiper positions, channel 0 in the low bits |

## Verification
The hardest case to reach is a store command that lands inside the busy window of the store before it. To get there, the bench opens a second frame right after a commit and issues a data write and a status read in it. It then releases chip select, all within the shortened busy window, and after the window ends it reads the target register to show that the write was refused. The deferral of stores is shown by a read of the same register inside the open frame, which must still return the old value.

// File: rtl/nvb_pkg.sv
package nvb_pkg;
  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_RD_WCR   = 4'd1,
    OP_WR_WCR   = 4'd2,
    OP_RD_DR    = 4'd3,
    OP_WR_DR    = 4'd4,
    OP_XFR_D2W  = 4'd5,
    OP_XFR_W2D  = 4'd6,
    OP_GXFR_D2W = 4'd7,
    OP_GXFR_W2D = 4'd8,
    OP_RD_STAT  = 4'd9
  } nvb_op_e;

  typedef enum logic [1:0] {
    PK_WRDR = 2'd0,
    PK_W2D  = 2'd1,
    PK_GW2D = 2'd2
  } nvb_pend_e;
endpackage

// File: rtl/nvb_frame.sv
module nvb_frame
  import nvb_pkg::*;
#(
  parameter int DW = 6,
  parameter int PW = 2,
  parameter int RW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wp_n,
  input  logic          wip,
  input  logic          cmd_en,
  input  nvb_op_e       cmd_op,
  input  logic [PW-1:0] cmd_pot,
  input  logic [RW-1:0] cmd_reg,
  input  logic [DW-1:0] cmd_data,
  output logic          pend_valid,
  output logic          commit,
  output nvb_pend_e     commit_kind,
  output logic [PW-1:0] commit_pot,
  output logic [RW-1:0] commit_reg,
  output logic [DW-1:0] commit_data
);
  logic          cs_q;
  logic          cs_rise;
  logic          is_store;
  logic          accept;
  logic          pv_d;
  nvb_pend_e     pk_d, pk_q;
  logic [PW-1:0] pp_d, pp_q;
  logic [RW-1:0] pr_d, pr_q;
  logic [DW-1:0] pd_d, pd_q;

  assign cs_rise  = cs_n & ~cs_q;
  assign is_store = (cmd_op == OP_WR_DR) || (cmd_op == OP_XFR_W2D) ||
                    (cmd_op == OP_GXFR_W2D);
  assign accept   = cmd_en & is_store & wp_n & ~wip;

  always_comb begin
    pv_d = pend_valid;
    pk_d = pk_q;
    pp_d = pp_q;
    pr_d = pr_q;
    pd_d = pd_q;
    if (cs_rise) begin
      pv_d = 1'b0;
    end else if (accept) begin
      pv_d = 1'b1;
      pp_d = cmd_pot;
      pr_d = cmd_reg;
      pd_d = cmd_data;
      case (cmd_op)
        OP_WR_DR:   pk_d = PK_WRDR;
        OP_XFR_W2D: pk_d = PK_W2D;
        default:    pk_d = PK_GW2D;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q       <= 1'b1;
      pend_valid <= 1'b0;
      pk_q       <= PK_WRDR;
      pp_q       <= '0;
      pr_q       <= '0;
      pd_q       <= '0;
    end else begin
      cs_q       <= cs_n;
      pend_valid <= pv_d;
      pk_q       <= pk_d;
      pp_q       <= pp_d;
      pr_q       <= pr_d;
      pd_q       <= pd_d;
    end
  end

  assign commit      = cs_rise & pend_valid;
  assign commit_kind = pk_q;
  assign commit_pot  = pp_q;
  assign commit_reg  = pr_q;
  assign commit_data = pd_q;
endmodule

// File: rtl/nvb_busy.sv
module nvb_busy #(
  parameter int BUSY_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] cnt_d, cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (start)
      cnt_d = CW'(BUSY_CYCLES);
    else if (cnt_q != '0)
      cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/nvb_bank.sv
module nvb_bank
  import nvb_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int NREG    = 4,
  parameter int DW      = 6,
  parameter int DR_SEED = 40,
  localparam int PW     = $clog2(NCH),
  localparam int RW     = $clog2(NREG)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wip,
  input  logic                          cmd_valid,
  input  nvb_op_e                       cmd_op,
  input  logic [PW-1:0]                 cmd_pot,
  input  logic [RW-1:0]                 cmd_reg,
  input  logic [DW-1:0]                 cmd_data,
  input  logic                          commit,
  input  nvb_pend_e                     commit_kind,
  input  logic [PW-1:0]                 commit_pot,
  input  logic [RW-1:0]                 commit_reg,
  input  logic [DW-1:0]                 commit_data,
  output logic                          cmd_en,
  output logic [NCH-1:0][NREG-1:0][DW-1:0] dr_all,
  output logic [NCH-1:0][DW-1:0]        w_all,
  output logic                          rd_valid,
  output logic [DW-1:0]                 rd_data
);
  logic          boot_q;
  logic          rdv_d;
  logic [DW-1:0] rdd_d;

  assign cmd_en = cmd_valid & ~boot_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [NREG-1:0][DW-1:0] dr_d, dr_q;
    logic [DW-1:0]           w_d, w_q;
    logic                    sel_cmd, sel_com;

    assign sel_cmd = (cmd_pot == PW'(c));
    assign sel_com = (commit_pot == PW'(c));

    always_comb begin
      dr_d = dr_q;
      w_d  = w_q;
      if (boot_q) begin
        w_d = dr_q[0];
      end else begin
        if (commit) begin
          if (commit_kind == PK_GW2D)
            dr_d[commit_reg] = w_q;
          else if (sel_com && commit_kind == PK_W2D)
            dr_d[commit_reg] = w_q;
          else if (sel_com)
            dr_d[commit_reg] = commit_data;
        end
        if (cmd_valid) begin
          case (cmd_op)
            OP_WR_WCR:   if (sel_cmd) w_d = cmd_data;
            OP_XFR_D2W:  if (sel_cmd) w_d = dr_q[cmd_reg];
            OP_GXFR_D2W: w_d = dr_q[cmd_reg];
            default:     ;
          endcase
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int r = 0; r < NREG; r++)
          dr_q[r] <= DW'(DR_SEED + NREG * c + r);
        w_q <= '0;
      end else begin
        dr_q <= dr_d;
        w_q  <= w_d;
      end
    end

    assign dr_all[c] = dr_q;
    assign w_all[c]  = w_q;
  end

  always_comb begin
    rdv_d = 1'b0;
    rdd_d = rd_data;
    if (cmd_en) begin
      case (cmd_op)
        OP_RD_DR:   begin rdv_d = 1'b1; rdd_d = dr_all[cmd_pot][cmd_reg]; end
        OP_RD_WCR:  begin rdv_d = 1'b1; rdd_d = w_all[cmd_pot];           end
        OP_RD_STAT: begin rdv_d = 1'b1; rdd_d = DW'(wip);                 end
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q   <= 1'b1;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      boot_q   <= 1'b0;
      rd_valid <= rdv_d;
      rd_data  <= rdd_d;
    end
  end
endmodule

// File: rtl/nvb_ctrl.sv
module nvb_ctrl
  import nvb_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int NREG        = 4,
  parameter int DW          = 6,
  parameter int DR_SEED     = 40,
  parameter int BUSY_CYCLES = 500000,
  localparam int PW         = $clog2(NCH),
  localparam int RW         = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wp_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [PW-1:0]     cmd_pot,
  input  logic [RW-1:0]     cmd_reg,
  input  logic [DW-1:0]     cmd_data,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  output logic              wip,
  output logic [NCH*DW-1:0] wiper_o
);
  nvb_op_e                       op;
  logic                          cmd_en;
  logic                          pend_valid;
  logic                          commit;
  nvb_pend_e                     commit_kind;
  logic [PW-1:0]                 commit_pot;
  logic [RW-1:0]                 commit_reg;
  logic [DW-1:0]                 commit_data;
  logic [NCH-1:0][NREG-1:0][DW-1:0] dr_all;
  logic [NCH-1:0][DW-1:0]        w_all;

  assign op = nvb_op_e'(cmd_op);

  nvb_frame #(.DW(DW), .PW(PW), .RW(RW)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .wip(wip),
    .cmd_en(cmd_en), .cmd_op(op), .cmd_pot(cmd_pot), .cmd_reg(cmd_reg),
    .cmd_data(cmd_data), .pend_valid(pend_valid), .commit(commit),
    .commit_kind(commit_kind), .commit_pot(commit_pot),
    .commit_reg(commit_reg), .commit_data(commit_data)
  );

  nvb_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(commit), .busy(wip)
  );

  nvb_bank #(.NCH(NCH), .NREG(NREG), .DW(DW), .DR_SEED(DR_SEED)) u_bank (
    .clk(clk), .rst_n(rst_n), .wip(wip), .cmd_valid(cmd_valid),
    .cmd_op(op), .cmd_pot(cmd_pot), .cmd_reg(cmd_reg), .cmd_data(cmd_data),
    .commit(commit), .commit_kind(commit_kind), .commit_pot(commit_pot),
    .commit_reg(commit_reg), .commit_data(commit_data), .cmd_en(cmd_en),
    .dr_all(dr_all), .w_all(w_all), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign wiper_o = w_all;
endmodule

// File: rtl/nvb_ctrl_chk.sv
module nvb_ctrl_chk #(
  parameter int NCH         = 4,
  parameter int NREG        = 4,
  parameter int DW          = 6,
  parameter int BUSY_CYCLES = 500000
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cs_n,
  input logic                   wp_n,
  input logic                   cmd_en,
  input logic [3:0]             cmd_op,
  input logic                   wip,
  input logic                   rd_valid,
  input logic [DW-1:0]          rd_data,
  input logic                   commit,
  input logic                   pend_valid,
  input logic [NCH*NREG*DW-1:0] dr_flat
);
  logic        cs_prev;
  logic [31:0] run;
  logic        store_op;

  assign store_op = (cmd_op == 4'd4) || (cmd_op == 4'd6) || (cmd_op == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev <= 1'b1;
      run     <= '0;
    end else begin
      cs_prev <= cs_n;
      run     <= wip ? run + 32'd1 : 32'd0;
    end
  end

  // R2, R10: registers move only at a chip-select rise
  a_r2_only_on_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs_n && !cs_prev) |=> $stable(dr_flat));

  a_r4_commit_sets_wip: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> wip);

  a_r4_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> (run == BUSY_CYCLES));

  a_r8_wp_discards: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && store_op && !wp_n && !pend_valid && !cs_n) |=> !pend_valid);

  a_r9_no_pending_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> !pend_valid);

  a_r3_status_answer: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && cmd_op == 4'd9) |=> (rd_valid && rd_data == DW'($past(wip))));
endmodule

bind nvb_ctrl nvb_ctrl_chk #(
  .NCH(NCH), .NREG(NREG), .DW(DW), .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .cmd_en(cmd_en),
  .cmd_op(cmd_op), .wip(wip), .rd_valid(rd_valid), .rd_data(rd_data),
  .commit(commit), .pend_valid(pend_valid), .dr_flat(dr_all)
);

// File: tb/nvb_ctrl_bench.sv
module nvb_ctrl_bench;
  localparam int BUSY = 12;
  localparam int SEED = 40;

  logic        clk, rst_n, cs_n, wp_n, cmd_valid;
  logic [3:0]  cmd_op;
  logic [1:0]  cmd_pot, cmd_reg;
  logic [5:0]  cmd_data;
  logic        rd_valid, wip;
  logic [5:0]  rd_data;
  logic [23:0] wiper_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [5:0] exp_q[$];
  string      tag_q[$];

  nvb_ctrl #(.BUSY_CYCLES(BUSY), .DR_SEED(SEED)) u_nvb_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_pot(cmd_pot),
    .cmd_reg(cmd_reg), .cmd_data(cmd_data), .rd_valid(rd_valid),
    .rd_data(rd_data), .wip(wip), .wiper_o(wiper_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [5:0] init_val(int c, int r);
    return 6'(SEED + 4 * c + r);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // monitor: pops expected answers as the design produces them
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R3 unexpected answer", rd_data, -1);
      end else begin
        logic [5:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data == e, t, rd_data, e);
      end
    end
  end

  task automatic cmd(input int op, input int pot, input int rg, input int d);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = 4'(op);
    cmd_pot   = 2'(pot);
    cmd_reg   = 2'(rg);
    cmd_data  = 6'(d);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd(input int op, input int pot, input int rg, input int e, input string tag);
    exp_q.push_back(6'(e));
    tag_q.push_back(tag);
    cmd(op, pot, rg, 0);
  endtask

  task automatic cs_low();
    @(negedge clk);
    cs_n = 1'b0;
  endtask

  task automatic cs_high();
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (wip && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic check_wiper(input int c, input int e, input string tag);
    check(wiper_o[6*c +: 6] == 6'(e), tag, wiper_o[6*c +: 6], e);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; cs_n = 1'b1; wp_n = 1'b1; cmd_valid = 1'b0;
    cmd_op = 4'd0; cmd_pot = 2'd0; cmd_reg = 2'd0; cmd_data = 6'd0;
    repeat (3) @(negedge clk);
    check(wip == 1'b0, "R1 wip in reset", wip, 0);
    check(rd_valid == 1'b0, "R1 rd_valid in reset", rd_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 4; c++) check_wiper(c, init_val(c, 0), "R1 wiper boot from R0");

    // R3 reads and reset pattern
    for (int r = 0; r < 4; r++) rd(3, 1, r, init_val(1, r), "R1 R3 register reset value");
    rd(1, 3, 0, init_val(3, 0), "R3 wiper read");
    rd(9, 0, 0, 0, "R3 status idle");

    // R11 direct wiper write, allowed under write protect
    wp_n = 1'b0;
    cmd(2, 2, 0, 7);
    check_wiper(2, 7, "R11 wiper write");
    wp_n = 1'b1;

    // R2 deferred store, R4 busy length
    cs_low();
    cmd(4, 1, 2, 33);
    rd(3, 1, 2, init_val(1, 2), "R2 old value before cs rise");
    cs_high();
    check(wip == 1'b1, "R4 wip after commit", wip, 1);
    // R9 store while busy is discarded, status still answers
    cs_low();
    cmd(4, 0, 3, 9);
    rd(9, 0, 0, 1, "R9 status during busy");
    cs_high();
    wait_idle(n);
    rd(3, 1, 2, 33, "R2 value after cs rise");
    rd(3, 0, 3, init_val(0, 3), "R9 busy store discarded");

    // R4 measured busy window on a fresh store; R5 single transfer
    cs_low();
    cmd(6, 2, 1, 0);
    cs_high();
    wait_idle(n);
    check(n == BUSY, "R4 busy length", n, BUSY);
    rd(3, 2, 1, 7, "R5 wiper to register");

    // R6 global wiper to register
    for (int c = 0; c < 4; c++) cmd(2, c, 0, c + 1);
    cs_low();
    cmd(8, 0, 3, 0);
    cs_high();
    wait_idle(n);
    check(n == BUSY, "R6 single busy window", n, BUSY);
    for (int c = 0; c < 4; c++) rd(3, c, 3, c + 1, "R6 global store");

    // R7 register to wiper, single and global
    cmd(5, 0, 2, 0);
    check_wiper(0, init_val(0, 2), "R7 single load");
    check(wip == 1'b0, "R7 no busy", wip, 0);
    for (int c = 0; c < 4; c++) cmd(2, c, 0, 60);
    cmd(7, 0, 3, 0);
    for (int c = 0; c < 4; c++) check_wiper(c, c + 1, "R7 global load");
    check(wip == 1'b0, "R7 global no busy", wip, 0);

    // R8 write protect
    wp_n = 1'b0;
    cs_low();
    cmd(4, 3, 0, 5);
    cs_high();
    check(wip == 1'b0, "R8 no busy under wp", wip, 0);
    cs_low();
    cmd(6, 1, 1, 0);
    cs_high();
    wp_n = 1'b1;
    rd(3, 3, 0, init_val(3, 0), "R8 write blocked");
    rd(3, 1, 1, init_val(1, 1), "R8 transfer blocked");

    // R10 frame without a store
    cs_low();
    rd(9, 0, 0, 0, "R10 status");
    cs_high();
    check(wip == 1'b0, "R10 no busy", wip, 0);
    rd(3, 0, 0, init_val(0, 0), "R10 register intact");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R3 missing answers", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule